// File: doc/BRIEF.md
# Radix-k Tree Priority Encoder

This block finds the highest-priority asserted bit in an N-bit request vector and reports its position together with a flag saying whether any request is present at all. It is the usual leading-zero detector used in normalisers, arbiters and match-line encoders. By default priority runs from the most significant request bit, so the reported position is the number of leading zeros. A parameter switches the block to lowest-bit-first order.

The encoder is a radix-K tree rather than one long priority chain. The ordered request vector is zero-extended up to the next power of K and cut into K-bit slices. A small leaf encoder handles each slice. Each higher level takes K child results, finds the first child that is valid, and places that child's number above the child's own position. The tree therefore has ceil(log_K N) levels, and its area grows linearly with N. An optional output register sits behind the root, for timing closure.

The width of the reported position is the number of tree levels times log2(K). K must be a power of two of at least 2, and N must be at least 2.

Top module: `prio_tree_enc`

## Requirements
- R1: `valid_o` is 1 exactly when at least one bit of `req_i` is 1.
- R2: With `LSB_FIRST` = 0, `index_o` equals the number of zero bits above the highest set bit of `req_i`, so `req_i[N-1]` reports 0 and `req_i[0]` reports N-1.
- R3: With `LSB_FIRST` = 1, `index_o` equals the bit position of the lowest set bit of `req_i`.
- R4: When `req_i` is all zero, `valid_o` is 0 and `index_o` is 0.
- R5: When N is not a power of K, the zero-extended positions are never reported: while `valid_o` is 1, `index_o` is below N, including when only the lowest-priority real bit is set.
- R6: When several bits are set, only the position of the highest-priority one is reported, whatever the other bits are.
- R7: With `REG_OUT` = 1, the outputs show the encoding of the `req_i` sampled at the previous rising `clk` edge. While `rst_n` is low, both outputs are held at 0.
- R8: With `REG_OUT` = 0, the outputs follow `req_i` within the same cycle, with no clock edge in between.
- R9: The `index_o` width is L*log2(K), where L is the smallest integer with K^L >= N (at least 1). This gives 4 bits for N=16, K=4 and 6 bits for N=50, K=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| req_i | input | N | Request vector to encode |
| valid_o | output | 1 | At least one request bit is set |
| index_o | output | L*log2(K) | Position of the highest-priority set bit (0 when none) |

## Verification
A fault in a leaf or join node changes the root result at once, for any input whose winning bit lies under that node. A faulty node can stop blocking a lower-priority slice, leak a padded position, or pass a nonzero position from an idle child. Each of these shows at the ports in the same cycle, or one cycle later when the output register is on. Because of that, exhaustive sweeps of the 16-bit and padded 10-bit configurations reach every node with every slice pattern. One-hot and random vectors on a wider radix-8 build then exercise the multi-bit slice numbers.

// File: rtl/prio_tree_pkg.sv
package prio_tree_pkg;

  // Smallest L >= 1 with k**L >= n: the number of tree levels.
  function automatic int tree_levels(input int n, input int k);
    int  lv;
    longint span;
    lv   = 1;
    span = k;
    while (span < n) begin
      span = span * k;
      lv   = lv + 1;
    end
    return lv;
  endfunction

  // Integer power used for padded width and per-level node counts.
  function automatic int int_pow(input int base, input int expo);
    int acc;
    acc = 1;
    for (int e = 0; e < expo; e++) acc = acc * base;
    return acc;
  endfunction

endpackage

// File: rtl/pe_base_enc.sv
// Leaf encoder: lowest bit position wins inside a K-bit slice.
module pe_base_enc #(
  parameter int K = 4,
  localparam int LK = $clog2(K)
) (
  input  logic [K-1:0]  bits_i,
  output logic          any_o,
  output logic [LK-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = K - 1; i >= 0; i--) begin
      if (bits_i[i]) pos_o = i[LK-1:0];
    end
    any_o = |bits_i;
  end
endmodule

// File: rtl/pe_combine.sv
// Join node: picks the first valid child and prefixes its number.
module pe_combine #(
  parameter int K  = 4,
  parameter int CW = 2,
  localparam int LK = $clog2(K)
) (
  input  logic [K-1:0]         cv_i,
  input  logic [K-1:0][CW-1:0] ci_i,
  output logic                 v_o,
  output logic [CW+LK-1:0]     idx_o
);
  logic [LK-1:0] sel_w;

  pe_base_enc #(.K(K)) u_pick (
    .bits_i (cv_i),
    .any_o  (v_o),
    .pos_o  (sel_w)
  );

  // An idle child carries position 0, so an idle join yields 0 as well.
  assign idx_o = {sel_w, ci_i[sel_w]};
endmodule

// File: rtl/pe_out_stage.sv
// Optional register behind the tree root.
module pe_out_stage #(
  parameter int W   = 4,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_d,
  input  logic [W-1:0] i_d,
  output logic         v_q,
  output logic [W-1:0] i_q
);
  if (REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        i_q <= '0;
      end else begin
        v_q <= v_d;
        i_q <= i_d;
      end
    end
  end else begin : g_wire
    assign v_q = v_d;
    assign i_q = i_d;
  end
endmodule

// File: rtl/prio_tree_enc.sv
module prio_tree_enc
  import prio_tree_pkg::*;
#(
  parameter int N         = 16,
  parameter int K         = 4,
  parameter bit LSB_FIRST = 1'b0,
  parameter bit REG_OUT   = 1'b1,
  localparam int LK = $clog2(K),
  localparam int LV = tree_levels(N, K),
  localparam int IW = LV * LK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] index_o
);
  localparam int NP = int_pow(K, LV);

  logic [NP-1:0] ord_w;     // priority-ordered, zero-padded requests
  logic          tree_v;    // root valid
  logic [IW-1:0] tree_idx;  // root position

  // Position 0 of ord_w is always the highest-priority request.
  for (genvar p = 0; p < NP; p++) begin : g_ord
    if (p >= N) begin : g_pad
      assign ord_w[p] = 1'b0;
    end else if (LSB_FIRST) begin : g_lsb
      assign ord_w[p] = req_i[p];
    end else begin : g_msb
      assign ord_w[p] = req_i[N-1-p];
    end
  end

  // Level j holds NP/K^(j+1) nodes, each with a (j+1)*LK bit position.
  for (genvar j = 0; j < LV; j++) begin : lvl
    localparam int CNT = NP / int_pow(K, j + 1);
    localparam int W   = (j + 1) * LK;
    logic [CNT-1:0]        nv;
    logic [CNT-1:0][W-1:0] ni;
    for (genvar g = 0; g < CNT; g++) begin : node
      if (j == 0) begin : g_leaf
        pe_base_enc #(.K(K)) u_leaf (
          .bits_i (ord_w[g*K +: K]),
          .any_o  (nv[g]),
          .pos_o  (ni[g])
        );
      end else begin : g_join
        pe_combine #(.K(K), .CW(W - LK)) u_join (
          .cv_i  (lvl[j-1].nv[g*K +: K]),
          .ci_i  (lvl[j-1].ni[g*K +: K]),
          .v_o   (nv[g]),
          .idx_o (ni[g])
        );
      end
    end
  end

  assign tree_v   = lvl[LV-1].nv[0];
  assign tree_idx = lvl[LV-1].ni[0];

  pe_out_stage #(.W(IW), .REG(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .v_d   (tree_v),
    .i_d   (tree_idx),
    .v_q   (valid_o),
    .i_q   (index_o)
  );
endmodule

// File: rtl/prio_tree_enc_chk.sv
module prio_tree_enc_chk #(
  parameter int N         = 16,
  parameter int K         = 4,
  parameter bit LSB_FIRST = 1'b0,
  parameter bit REG_OUT   = 1'b1,
  parameter int IW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_i,
  input logic          tree_v,
  input logic [IW-1:0] tree_idx,
  input logic          valid_o,
  input logic [IW-1:0] index_o
);
  function automatic int first_pos(input logic [N-1:0] v);
    for (int p = 0; p < N; p++) begin
      if (LSB_FIRST ? v[p] : v[N-1-p]) return p;
    end
    return 0;
  endfunction

  AST_VALID_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    tree_v == (|req_i)); // R1

  AST_FIRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tree_v |-> int'(tree_idx) == first_pos(req_i)); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tree_v |-> tree_idx == '0); // R4

  AST_NO_PAD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    tree_v |-> int'(tree_idx) < N); // R5

  if (REG_OUT) begin : g_reg_chk
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (valid_o == $past(tree_v)) && (index_o == $past(tree_idx))); // R7
  end else begin : g_comb_chk
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o == tree_v) && (index_o == tree_idx)); // R8
  end
endmodule

bind prio_tree_enc prio_tree_enc_chk #(
  .N(N), .K(K), .LSB_FIRST(LSB_FIRST), .REG_OUT(REG_OUT), .IW(IW)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .tree_v   (tree_v),
  .tree_idx (tree_idx),
  .valid_o  (valid_o),
  .index_o  (index_o)
);

// File: tb/test_prio_tree_enc.sv
`timescale 1ns/1ps
module test_prio_tree_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // A: N=16 K=4 MSB-first registered
  logic [15:0] req_a = '0;
  logic        va;
  logic [3:0]  ia;
  // B: N=10 K=4 LSB-first combinational (padded)
  logic [9:0]  req_b = '0;
  logic        vb;
  logic [3:0]  ib;
  // C: N=50 K=8 MSB-first combinational (padded)
  logic [49:0] req_c = '0;
  logic        vc;
  logic [5:0]  ic;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  prio_tree_enc #(.N(16), .K(4), .LSB_FIRST(1'b0), .REG_OUT(1'b1)) i_prio_tree_enc (
    .clk(clk), .rst_n(rst_n), .req_i(req_a), .valid_o(va), .index_o(ia));
  prio_tree_enc #(.N(10), .K(4), .LSB_FIRST(1'b1), .REG_OUT(1'b0)) i_prio_tree_enc_pad (
    .clk(clk), .rst_n(rst_n), .req_i(req_b), .valid_o(vb), .index_o(ib));
  prio_tree_enc #(.N(50), .K(8), .LSB_FIRST(1'b0), .REG_OUT(1'b0)) i_prio_tree_enc_wide (
    .clk(clk), .rst_n(rst_n), .req_i(req_c), .valid_o(vc), .index_o(ic));

  function automatic int ref_pos(input logic [63:0] v, input int n, input bit lsb);
    for (int p = 0; p < n; p++) begin
      if (lsb ? v[p] : v[n-1-p]) return p;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Checks valid and index against the loop model.
  task automatic check_enc(input string tag, input logic v, input logic [31:0] i,
                           input logic [63:0] vec, input int n, input bit lsb);
    int pos;
    pos = ref_pos(vec, n, lsb);
    check("R1 valid", {31'b0, v}, (pos >= 0) ? 32'd1 : 32'd0);
    check(tag, i, (pos >= 0) ? pos : 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_a = 16'hFFFF;
    repeat (2) @(negedge clk);
    check("R7 reset valid", {31'b0, va}, 32'd0);
    check("R7 reset index", {28'b0, ia}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latency;
    @(negedge clk);
    req_a = 16'h0001;
    @(negedge clk);
    check("R7 captured index", {28'b0, ia}, 32'd15);
    req_a = 16'h8000;
    #1;
    check("R7 no same-cycle path", {28'b0, ia}, 32'd15);
    @(negedge clk);
    check("R7 next cycle index", {28'b0, ia}, 32'd0);
  endtask

  task automatic t_exh16;
    logic [15:0] prev;
    prev = '0;
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      if (v > 0)
        check_enc(prev == 0 ? "R4 idle index" : ($countones(prev) > 1 ? "R6 multi-bit" : "R2 single-bit"),
                  va, {28'b0, ia}, {48'b0, prev}, 16, 1'b0);
      req_a = v[15:0];
      prev  = v[15:0];
    end
    @(negedge clk);
    check_enc("R6 multi-bit", va, {28'b0, ia}, {48'b0, prev}, 16, 1'b0);
  endtask

  task automatic t_pad_lsb;
    req_b = 10'h0;
    #1;
    req_b = 10'h088;
    #1;
    check("R8 same-cycle index", {28'b0, ib}, 32'd3);
    for (int v = 0; v < 1024; v++) begin
      req_b = v[9:0];
      #1;
      check_enc(v == 0 ? "R4 idle index" : "R3 lowest-bit index", vb, {28'b0, ib}, {54'b0, v[9:0]}, 10, 1'b1);
      if (vb === 1'b1) check("R5 below N", {31'b0, (ib < 4'd10)}, 32'd1);
    end
    req_b = 10'h200;
    #1;
    check("R5 last real bit", {28'b0, ib}, 32'd9);
  endtask

  task automatic t_wide;
    check("R9 width N16", $bits(ia), 32'd4);
    check("R9 width N50", $bits(ic), 32'd6);
    req_c = '0;
    #1;
    check_enc("R4 idle index", vc, {26'b0, ic}, 64'b0, 50, 1'b0);
    for (int p = 0; p < 50; p++) begin
      req_c = 50'b1 << p;
      #1;
      check_enc("R2 one-hot", vc, {26'b0, ic}, {14'b0, req_c}, 50, 1'b0);
    end
    req_c = 50'b1;
    #1;
    check("R5 lowest real bit", {26'b0, ic}, 32'd49);
    for (int r = 0; r < 3000; r++) begin
      logic [63:0] rnd;
      rnd = {$urandom(), $urandom()};
      if (r % 2 == 1) rnd = rnd & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      req_c = rnd[49:0];
      #1;
      check_enc("R6 random", vc, {26'b0, ic}, {14'b0, req_c}, 50, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_exh16();
    t_pad_lsb();
    t_wide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule